// File: doc/BRIEF.md
# Inter-Subarray Row Copy Sequencer

This block sits on the controller side of a DRAM channel. It copies one entire row into a row of another subarray in the same bank, and the data never passes over the external data bus. A request names the bank, source subarray and row, and destination subarray and row. The sequencer first opens the source row. It then passes the sensed row from one row buffer to the row buffer of the next subarray, one adjacent hop per movement command, until the contents reach the destination subarray. It then activates the destination row, which writes the buffer contents into the cells.

All timing gaps are counted in clock cycles and each one is a separate parameter. These are activate-to-movement, movement duration, active time and precharge time. Once the destination row has been open for the active time, every subarray the copy touched is precharged, one command per cycle. After the precharge time has passed, a single-cycle done pulse is given. Two kinds of request are refused with an error pulse and no commands: a request whose two rows are in the same subarray, and a request whose two rows are in different banks.

Top module: `row_copy_seq`

## Requirements
- R1: After reset the sequencer is idle: busy, done, err and cmd_valid are low and req_ready is high.
- R2: A valid request accepted on a clock edge produces an activate (cmd_op 1) to the source subarray and source row in the cycle right after that edge, and busy rises in the same cycle.
- R3: The first movement (cmd_op 2) follows the source activate by T_ACT2MOV cycles, and later movements are T_MOV cycles apart. Each movement names the sending subarray in cmd_sa and the receiving subarray, one index away, in cmd_sa_to.
- R4: Hops step upward when the destination subarray index is greater than the source index, and downward otherwise. Exactly |dst - src| movements are issued.
- R5: The destination activate (cmd_op 1, destination subarray and row) comes T_MOV cycles after the last movement.
- R6: Each movement is issued only when the sending row buffer is open and the receiving one is precharged.
- R7: T_RAS cycles after the destination activate, a precharge (cmd_op 3) goes to every touched subarray, one per cycle. The walk starts at the destination and ends at the source.
- R8: done is a one-cycle pulse T_RP cycles after the last precharge. busy stays high from the cycle after acceptance until done rises, and it is low while done is high.
- R9: A request with equal source and destination subarrays, or with differing banks, gives a one-cycle err pulse in the next cycle. No command is issued and busy stays low.
- R10: While busy is high, req_ready is low and requests have no effect on the command stream.
- R11: Every command of one copy carries the bank of that request on cmd_bank. cmd_op 0 means no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_src_bank | input | BANK_W | Bank of the source row |
| req_src_sa | input | SA_W | Source subarray index |
| req_src_row | input | ROW_W | Source row within its subarray |
| req_dst_bank | input | BANK_W | Bank of the destination row |
| req_dst_sa | input | SA_W | Destination subarray index |
| req_dst_row | input | ROW_W | Destination row within its subarray |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle copy-complete pulse |
| err | output | 1 | One-cycle rejected-request pulse |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_op | output | 2 | 0 none, 1 activate, 2 movement, 3 precharge |
| cmd_bank | output | BANK_W | Target bank |
| cmd_sa | output | SA_W | Target (or sending) subarray |
| cmd_sa_to | output | SA_W | Receiving subarray of a movement |
| cmd_row | output | ROW_W | Row of an activate |

## Verification
Take n as the count of cycles after the accepting edge, with H hops. The source activate is due at n=0. Movement k is due at T_ACT2MOV + k*T_MOV, and the destination activate at T_ACT2MOV + H*T_MOV. Precharge j follows T_RAS cycles after the destination activate plus j, and done comes T_RP cycles after the last precharge. A rejected request shows err at n=0. The bench computes the expected command for every single cycle n from these formulas and samples on the falling edge. As a result, a command that arrives one cycle early or late is reported as a mismatch in the cycle where it was expected.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_MOVE = 2'd2,
    CMD_PRE  = 2'd3
  } rcs_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOP_WAIT,
    ST_DST_WAIT,
    ST_PRE,
    ST_RP_WAIT
  } rcs_state_e;

  function automatic int rcs_max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rcs_req_check.sv
module rcs_req_check #(
  parameter int BANK_W = 3,
  parameter int SA_W   = 4
) (
  input  logic [BANK_W-1:0] src_bank,
  input  logic [BANK_W-1:0] dst_bank,
  input  logic [SA_W-1:0]   src_sa,
  input  logic [SA_W-1:0]   dst_sa,
  output logic              legal
);
  // a copy must stay in one bank and must cross at least one subarray boundary
  function automatic logic is_legal(logic [BANK_W-1:0] sb, logic [BANK_W-1:0] db,
                                    logic [SA_W-1:0] ss, logic [SA_W-1:0] ds);
    return (sb == db) && (ss != ds);
  endfunction

  assign legal = is_legal(src_bank, dst_bank, src_sa, dst_sa);
endmodule

// File: rtl/rcs_wait_timer.sv
module rcs_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rcs_sa_stepper.sv
module rcs_sa_stepper #(
  parameter int SA_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SA_W-1:0] load_cur,
  input  logic [SA_W-1:0] load_tgt,
  input  logic            step,
  output logic [SA_W-1:0] cur,
  output logic [SA_W-1:0] nxt,
  output logic            at_tgt
);
  logic [SA_W-1:0] cur_q, tgt_q;

  // one subarray toward the target: up when it lies above, down otherwise
  function automatic logic [SA_W-1:0] toward(logic [SA_W-1:0] c, logic [SA_W-1:0] t);
    if (t > c)      return c + 1'b1;
    else if (t < c) return c - 1'b1;
    else            return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      tgt_q <= '0;
    end else if (load) begin
      cur_q <= load_cur;
      tgt_q <= load_tgt;
    end else if (step) begin
      cur_q <= toward(cur_q, tgt_q);
    end
  end

  assign cur    = cur_q;
  assign nxt    = toward(cur_q, tgt_q);
  assign at_tgt = (cur_q == tgt_q);
endmodule

// File: rtl/row_copy_seq.sv
module row_copy_seq #(
  parameter int BANK_W    = 3,
  parameter int SA_W      = 4,
  parameter int ROW_W     = 9,
  parameter int T_ACT2MOV = 5,
  parameter int T_MOV     = 2,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_src_bank,
  input  logic [SA_W-1:0]   req_src_sa,
  input  logic [ROW_W-1:0]  req_src_row,
  input  logic [BANK_W-1:0] req_dst_bank,
  input  logic [SA_W-1:0]   req_dst_sa,
  input  logic [ROW_W-1:0]  req_dst_row,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [SA_W-1:0]   cmd_sa,
  output logic [SA_W-1:0]   cmd_sa_to,
  output logic [ROW_W-1:0]  cmd_row
);
  import rcs_pkg::*;

  localparam int T_MAX = rcs_max4(T_ACT2MOV, T_MOV, T_RAS, T_RP);
  localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);
  localparam logic [CNT_W-1:0] LD_A2M = CNT_W'(T_ACT2MOV - 1);
  localparam logic [CNT_W-1:0] LD_MOV = CNT_W'(T_MOV - 1);
  localparam logic [CNT_W-1:0] LD_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);

  rcs_state_e        state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic [SA_W-1:0]   src_sa_q;
  logic [ROW_W-1:0]  dst_row_q;

  // named internal events
  logic              req_legal, accept_ok, accept_bad, wait_over;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic              s_load, s_step, s_at_tgt;
  logic [SA_W-1:0]   s_cur_in, s_tgt_in, s_cur, s_nxt;
  rcs_cmd_e          iss_op;
  logic [SA_W-1:0]   iss_sa, iss_to;
  logic [ROW_W-1:0]  iss_row;
  logic              iss_done;

  rcs_req_check #(.BANK_W(BANK_W), .SA_W(SA_W)) u_check (
    .src_bank (req_src_bank),
    .dst_bank (req_dst_bank),
    .src_sa   (req_src_sa),
    .dst_sa   (req_dst_sa),
    .legal    (req_legal)
  );

  rcs_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (wait_over)
  );

  rcs_sa_stepper #(.SA_W(SA_W)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (s_load),
    .load_cur (s_cur_in),
    .load_tgt (s_tgt_in),
    .step     (s_step),
    .cur      (s_cur),
    .nxt      (s_nxt),
    .at_tgt   (s_at_tgt)
  );

  assign accept_ok  = (state_q == ST_IDLE) && req_valid && req_legal;
  assign accept_bad = (state_q == ST_IDLE) && req_valid && !req_legal;

  always_comb begin
    state_d  = state_q;
    t_load   = 1'b0;
    t_val    = '0;
    s_load   = 1'b0;
    s_cur_in = '0;
    s_tgt_in = '0;
    s_step   = 1'b0;
    iss_op   = CMD_NOP;
    iss_sa   = '0;
    iss_to   = '0;
    iss_row  = '0;
    iss_done = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept_ok) begin
        iss_op   = CMD_ACT;
        iss_sa   = req_src_sa;
        iss_row  = req_src_row;
        t_load   = 1'b1;
        t_val    = LD_A2M;
        s_load   = 1'b1;
        s_cur_in = req_src_sa;
        s_tgt_in = req_dst_sa;
        state_d  = ST_HOP_WAIT;
      end
      ST_HOP_WAIT: if (wait_over) begin
        t_load = 1'b1;
        if (s_at_tgt) begin
          // row has reached the destination buffer: write it into the cells
          iss_op   = CMD_ACT;
          iss_sa   = s_cur;
          iss_row  = dst_row_q;
          t_val    = LD_RAS;
          s_load   = 1'b1;
          s_cur_in = s_cur;
          s_tgt_in = src_sa_q;
          state_d  = ST_DST_WAIT;
        end else begin
          iss_op = CMD_MOVE;
          iss_sa = s_cur;
          iss_to = s_nxt;
          t_val  = LD_MOV;
          s_step = 1'b1;
        end
      end
      ST_DST_WAIT: if (wait_over) begin
        iss_op  = CMD_PRE;
        iss_sa  = s_cur;
        s_step  = 1'b1;
        state_d = ST_PRE;
      end
      ST_PRE: begin
        iss_op = CMD_PRE;
        iss_sa = s_cur;
        if (s_at_tgt) begin
          t_load  = 1'b1;
          t_val   = LD_RP;
          state_d = ST_RP_WAIT;
        end else begin
          s_step = 1'b1;
        end
      end
      ST_RP_WAIT: if (wait_over) begin
        iss_done = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bank_q    <= '0;
      src_sa_q  <= '0;
      dst_row_q <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= CMD_NOP;
      cmd_sa    <= '0;
      cmd_sa_to <= '0;
      cmd_row   <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_valid <= (iss_op != CMD_NOP);
      cmd_op    <= iss_op;
      cmd_sa    <= iss_sa;
      cmd_sa_to <= iss_to;
      cmd_row   <= iss_row;
      done      <= iss_done;
      err       <= accept_bad;
      if (accept_ok) begin
        bank_q    <= req_src_bank;
        src_sa_q  <= req_src_sa;
        dst_row_q <= req_dst_row;
      end
    end
  end

  assign cmd_bank  = bank_q;
  assign busy      = (state_q != ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int BANK_W = 3,
  parameter int SA_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [SA_W-1:0]   cmd_sa,
  input logic [SA_W-1:0]   cmd_sa_to
);
  localparam int NSA = 1 << SA_W;

  logic [NSA-1:0] open_q;
  logic is_act, is_move, is_pre;

  assign is_act  = cmd_valid && (cmd_op == 2'd1);
  assign is_move = cmd_valid && (cmd_op == 2'd2);
  assign is_pre  = cmd_valid && (cmd_op == 2'd3);

  // row-buffer state rebuilt from the command stream alone
  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= '0;
    else begin
      if (is_act)  open_q[cmd_sa]    <= 1'b1;
      if (is_move) open_q[cmd_sa_to] <= 1'b1;
      if (is_pre)  open_q[cmd_sa]    <= 1'b0;
    end
  end

  AST_MOVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    is_move |-> (open_q[cmd_sa] && !open_q[cmd_sa_to])); // R6
  AST_MOVE_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    is_move |-> ((cmd_sa_to == cmd_sa + 1'b1) || (cmd_sa_to == cmd_sa - 1'b1))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (open_q == '0)); // R7
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy); // R8
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!cmd_valid && !busy)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R10
  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_bank)); // R11
endmodule

bind row_copy_seq rcs_checker #(.BANK_W(BANK_W), .SA_W(SA_W)) u_rcs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank),
  .cmd_sa    (cmd_sa),
  .cmd_sa_to (cmd_sa_to)
);

// File: tb/test_row_copy_seq.sv
module test_row_copy_seq;
  localparam int BW = 3, SW = 4, RW = 9;
  localparam int TA = 5, TM = 2, TR = 8, TP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [BW-1:0] req_src_bank = '0, req_dst_bank = '0;
  logic [SW-1:0] req_src_sa = '0, req_dst_sa = '0;
  logic [RW-1:0] req_src_row = '0, req_dst_row = '0;
  logic req_ready, busy, done, err, cmd_valid;
  logic [1:0] cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [SW-1:0] cmd_sa, cmd_sa_to;
  logic [RW-1:0] cmd_row;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  row_copy_seq #(.BANK_W(BW), .SA_W(SW), .ROW_W(RW),
                 .T_ACT2MOV(TA), .T_MOV(TM), .T_RAS(TR), .T_RP(TP)) i_row_copy_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src_bank(req_src_bank), .req_src_sa(req_src_sa), .req_src_row(req_src_row),
    .req_dst_bank(req_dst_bank), .req_dst_sa(req_dst_sa), .req_dst_row(req_dst_row),
    .busy(busy), .done(done), .err(err), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_sa(cmd_sa), .cmd_sa_to(cmd_sa_to), .cmd_row(cmd_row));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  // R1
  task automatic t_reset();
    check(busy == 0, "R1 busy", busy, 0);
    check(req_ready == 1, "R1 ready", req_ready, 1);
    check(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
    check(done == 0 && err == 0, "R1 done/err", {done, err}, 0);
  endtask

  // full copy, every cycle compared with the timing formulas; optional request while busy (R10)
  task automatic t_copy(input int bank, input int s, input int srow,
                        input int d, input int drow, input bit inject);
    int h, dir, t_dact, t_pre0, t_done;
    h      = (d > s) ? d - s : s - d;
    dir    = (d > s) ? 1 : -1;            // R4
    t_dact = TA + h * TM;
    t_pre0 = t_dact + TR;
    t_done = t_pre0 + h + TP;
    @(negedge clk);
    check(req_ready == 1, "R2 ready before request", req_ready, 1);
    req_src_bank = BW'(bank); req_dst_bank = BW'(bank);
    req_src_sa = SW'(s); req_dst_sa = SW'(d);
    req_src_row = RW'(srow); req_dst_row = RW'(drow);
    req_valid = 1'b1;
    for (int n = 0; n <= t_done + 4; n++) begin
      int eop, esa, eto, erow;
      string tag;
      @(negedge clk);
      if (n == 0) req_valid = 1'b0;
      if (inject && n == 2) begin
        req_src_sa = SW'(0); req_dst_sa = SW'(1); req_valid = 1'b1;
      end
      if (inject && n == t_done - 1) req_valid = 1'b0;
      eop = 0; esa = 0; eto = 0; erow = 0; tag = "R3 idle gap";
      if (n == 0) begin
        eop = 1; esa = s; erow = srow; tag = "R2 source activate";
      end else if (n >= TA && n < t_dact && ((n - TA) % TM) == 0) begin
        eop = 2; esa = s + dir * ((n - TA) / TM); eto = esa + dir; tag = "R4 movement";
      end else if (n == t_dact) begin
        eop = 1; esa = d; erow = drow; tag = "R5 destination activate";
      end else if (n >= t_pre0 && n <= t_pre0 + h) begin
        eop = 3; esa = d - dir * (n - t_pre0); tag = "R7 precharge";
      end else if (n > t_done) begin
        tag = "R10 no command after copy";
      end
      check(cmd_op == 2'(eop) && cmd_valid == (eop != 0), tag, cmd_op, eop);
      if (eop != 0) begin
        check(cmd_sa == SW'(esa), tag, cmd_sa, esa);
        check(cmd_bank == BW'(bank), "R11 bank", cmd_bank, bank);
      end
      if (eop == 1) check(cmd_row == RW'(erow), tag, cmd_row, erow);
      if (eop == 2) check(cmd_sa_to == SW'(eto), "R3 receiver", cmd_sa_to, eto);
      check(busy == (n < t_done), "R8 busy", busy, n < t_done);
      check(done == (n == t_done), "R8 done", done, n == t_done);
      if (inject && n > 2 && n < t_done)
        check(req_ready == 0, "R10 ready low while busy", req_ready, 0);
    end
  endtask

  // R9
  task automatic t_reject(input int sb, input int db, input int s, input int d);
    @(negedge clk);
    req_src_bank = BW'(sb); req_dst_bank = BW'(db);
    req_src_sa = SW'(s); req_dst_sa = SW'(d);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(err == 1, "R9 err pulse", err, 1);
    check(busy == 0, "R9 busy stays low", busy, 0);
    check(cmd_valid == 0, "R9 no command", cmd_valid, 0);
    for (int n = 1; n < 6; n++) begin
      @(negedge clk);
      check(err == 0, "R9 err one cycle", err, 0);
      check(cmd_valid == 0 && busy == 0, "R9 silent", {cmd_valid, busy}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy(2, 2, 17, 5, 300, 1'b0);   // upward, three hops
    t_copy(5, 7, 3, 6, 511, 1'b0);    // downward, adjacent
    t_copy(1, 9, 100, 3, 42, 1'b1);   // downward, six hops, request while busy
    t_copy(7, 0, 0, 15, 511, 1'b0);   // widest span
    t_reject(3, 3, 4, 4);             // same subarray
    t_reject(1, 2, 4, 6);             // different banks
    t_copy(0, 14, 8, 15, 9, 1'b0);    // upward, adjacent after rejects
    summary();
  end
endmodule